// File: doc/BRIEF.md
# Interrupt Flag and Enable Controller

This block collects interrupt requests from a few hardware sources and gives software a small register view of them. Each source sets its own sticky flag with a single-cycle pulse. Software reads the flags through an 8-bit register port and clears the ones it has handled by writing ones to them. A separate mask register decides which flags count as pending. That mask register is written in set mode or clear mode: the top data bit chooses the mode, and the lower bits choose which mask bits change.

One registered level output, `irq`, goes high while a qualifying flag is both set and enabled. Only the shift-register flag (bit 2) and the first timer flag (bit 6) qualify. The second timer flag (bit 5) can be set, enabled and read back like the others, but it never drives the output. Reads return their data one cycle after the read strobe. The block does no prioritisation and no vectoring.

Top module: `ifc_ctrl`

## Requirements
- R1: After reset, all flag bits are 0, all enable bits are 0, `irq` is 0 and `rd_data` is 0.
- R2: A 1 on bit i of `src_set` for one cycle sets flag i at the next clock edge. The flag then stays set until software clears it.
- R3: A write to select 13 clears each flag whose `wr_data` bit (bits 6:0) is 1. Flags written as 0 keep their value.
- R4: A read of select 13 presents, one cycle after the strobe, the flags on bits 6:0. Bit 7 is 1 exactly when some flag is both set and enabled.
- R5: A write to select 14 with `wr_data[7]`=1 sets each enable bit whose `wr_data` bit (bits 6:0) is 1. The other enable bits keep their value.
- R6: A write to select 14 with `wr_data[7]`=0 clears each enable bit whose `wr_data` bit is 1. The other enable bits keep their value.
- R7: A read of select 14 presents, one cycle after the strobe, the enable bits on bits 6:0 and a constant 1 on bit 7.
- R8: `irq` equals, one cycle later, the OR over flag bits 2 and 6 of (flag AND enable). Flag bit 5 and the other flags never raise `irq`.
- R9: When a set pulse and a software clear reach the same flag in the same cycle, the flag ends up set.
- R10: Writes to any select other than 13 and 14 change no flag and no enable bit. Reads of those selects return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| src_set | input | 7 | Per-source flag set pulses |
| reg_sel | input | 4 | Register select |
| rd_en | input | 1 | Read strobe |
| wr_en | input | 1 | Write strobe |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Registered read data |
| irq | output | 1 | Registered level interrupt output |

## Verification
The bench builds the block with its default parameters: seven sources, flag select 13, enable select 14, and an output mask covering bits 2 and 6. With these values it can show that the second timer flag counts as pending in the read-back bit 7 but still leaves `irq` low. It also drives a set pulse and a software clear into the first timer flag in the same cycle, and it writes to unused selects to show that they change no state.

// File: rtl/ifc_pkg.sv
package ifc_pkg;
  // Decoded access for one cycle of the register port.
  typedef struct packed {
    logic wr_flag;
    logic wr_ena;
    logic rd_flag;
    logic rd_ena;
  } ifc_access_t;
endpackage

// File: rtl/ifc_decode.sv
module ifc_decode
  import ifc_pkg::*;
#(
  parameter int SEL_W    = 4,
  parameter int FLAG_SEL = 13,
  parameter int ENA_SEL  = 14
) (
  input  logic [SEL_W-1:0] reg_sel,
  input  logic             rd_en,
  input  logic             wr_en,
  output ifc_access_t      acc
);
  localparam logic [SEL_W-1:0] FlagSelV = SEL_W'(FLAG_SEL);
  localparam logic [SEL_W-1:0] EnaSelV  = SEL_W'(ENA_SEL);

  always_comb begin
    acc.wr_flag = wr_en && (reg_sel == FlagSelV);
    acc.wr_ena  = wr_en && (reg_sel == EnaSelV);
    acc.rd_flag = rd_en && (reg_sel == FlagSelV);
    acc.rd_ena  = rd_en && (reg_sel == EnaSelV);
  end
endmodule

// File: rtl/ifc_flag_bank.sv
module ifc_flag_bank #(
  parameter int SRC_W = 7
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [SRC_W-1:0] set_pulse,
  input  logic             clr_en,
  input  logic [SRC_W-1:0] clr_bits,
  output logic [SRC_W-1:0] flags
);
  logic [SRC_W-1:0] flags_nxt;

  // Per-bit update: a hardware set pulse takes priority over a software clear.
  for (genvar g = 0; g < SRC_W; g++) begin : g_bit
    always_comb begin
      if (set_pulse[g])                flags_nxt[g] = 1'b1;
      else if (clr_en && clr_bits[g])  flags_nxt[g] = 1'b0;
      else                             flags_nxt[g] = flags[g];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) flags <= '0;
    else     flags <= flags_nxt;
  end
endmodule

// File: rtl/ifc_enable_bank.sv
module ifc_enable_bank #(
  parameter int SRC_W = 7
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr,
  input  logic             set_mode,
  input  logic [SRC_W-1:0] bits,
  output logic [SRC_W-1:0] ena
);
  always_ff @(posedge clk) begin
    if (rst)           ena <= '0;
    else if (wr) begin
      if (set_mode)    ena <= ena | bits;
      else             ena <= ena & ~bits;
    end
  end
endmodule

// File: rtl/ifc_irq_out.sv
module ifc_irq_out #(
  parameter int               SRC_W    = 7,
  parameter logic [SRC_W-1:0] IRQ_MASK = 7'b100_0100
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [SRC_W-1:0] flags,
  input  logic [SRC_W-1:0] ena,
  output logic             any_pending,
  output logic             irq
);
  logic [SRC_W-1:0] live;

  always_comb begin
    live        = flags & ena;
    any_pending = |live;
  end

  always_ff @(posedge clk) begin
    if (rst) irq <= 1'b0;
    else     irq <= |(live & IRQ_MASK);
  end
endmodule

// File: rtl/ifc_ctrl.sv
module ifc_ctrl
  import ifc_pkg::*;
#(
  parameter int               SRC_W    = 7,
  parameter int               SEL_W    = 4,
  parameter int               FLAG_SEL = 13,
  parameter int               ENA_SEL  = 14,
  parameter logic [SRC_W-1:0] IRQ_MASK = 7'b100_0100,
  localparam int              DATA_W   = SRC_W + 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [SRC_W-1:0]  src_set,
  input  logic [SEL_W-1:0]  reg_sel,
  input  logic              rd_en,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0] rd_data,
  output logic              irq
);
  ifc_access_t      acc;
  logic [SRC_W-1:0] flag_q;
  logic [SRC_W-1:0] ena_q;
  logic             pending;

  ifc_decode #(
    .SEL_W(SEL_W), .FLAG_SEL(FLAG_SEL), .ENA_SEL(ENA_SEL)
  ) u_dec (
    .reg_sel(reg_sel), .rd_en(rd_en), .wr_en(wr_en), .acc(acc)
  );

  ifc_flag_bank #(.SRC_W(SRC_W)) u_flags (
    .clk(clk), .rst(rst), .set_pulse(src_set),
    .clr_en(acc.wr_flag), .clr_bits(wr_data[SRC_W-1:0]),
    .flags(flag_q)
  );

  ifc_enable_bank #(.SRC_W(SRC_W)) u_ena (
    .clk(clk), .rst(rst), .wr(acc.wr_ena),
    .set_mode(wr_data[DATA_W-1]), .bits(wr_data[SRC_W-1:0]),
    .ena(ena_q)
  );

  ifc_irq_out #(.SRC_W(SRC_W), .IRQ_MASK(IRQ_MASK)) u_irq (
    .clk(clk), .rst(rst), .flags(flag_q), .ena(ena_q),
    .any_pending(pending), .irq(irq)
  );

  // Registered read port: data appears the cycle after the strobe.
  always_ff @(posedge clk) begin
    if (rst)              rd_data <= '0;
    else if (rd_en) begin
      if (acc.rd_flag)    rd_data <= {pending, flag_q};
      else if (acc.rd_ena) rd_data <= {1'b1, ena_q};
      else                rd_data <= '0;
    end
  end
endmodule

// File: rtl/ifc_ctrl_chk.sv
module ifc_ctrl_chk #(
  parameter int               SRC_W    = 7,
  parameter int               SEL_W    = 4,
  parameter int               FLAG_SEL = 13,
  parameter int               ENA_SEL  = 14,
  parameter logic [SRC_W-1:0] IRQ_MASK = 7'b100_0100
) (
  input logic             clk,
  input logic             rst,
  input logic [SRC_W-1:0] src_set,
  input logic [SEL_W-1:0] reg_sel,
  input logic             rd_en,
  input logic             wr_en,
  input logic [SRC_W:0]   wr_data,
  input logic [SRC_W:0]   rd_data,
  input logic             irq,
  input logic [SRC_W-1:0] flag_q,
  input logic [SRC_W-1:0] ena_q
);
  localparam logic [SEL_W-1:0] FS = SEL_W'(FLAG_SEL);
  localparam logic [SEL_W-1:0] ES = SEL_W'(ENA_SEL);

  a_r9_set_beats_clear: assert property (@(posedge clk) disable iff (rst)
    (src_set != '0) |=> ((flag_q & $past(src_set)) == $past(src_set)));

  a_r3_clear_written: assert property (@(posedge clk) disable iff (rst)
    (wr_en && reg_sel == FS) |=>
      ((flag_q & $past(wr_data[SRC_W-1:0] & ~src_set)) == '0));

  a_r5_enable_set: assert property (@(posedge clk) disable iff (rst)
    (wr_en && reg_sel == ES && wr_data[SRC_W]) |=>
      ((ena_q & $past(wr_data[SRC_W-1:0])) == $past(wr_data[SRC_W-1:0])));

  a_r6_enable_clear: assert property (@(posedge clk) disable iff (rst)
    (wr_en && reg_sel == ES && !wr_data[SRC_W]) |=>
      ((ena_q & $past(wr_data[SRC_W-1:0])) == '0));

  a_r7_ena_read_top: assert property (@(posedge clk) disable iff (rst)
    (rd_en && reg_sel == ES) |=> rd_data[SRC_W]);

  a_r4_flag_read: assert property (@(posedge clk) disable iff (rst)
    (rd_en && reg_sel == FS) |=> (rd_data[SRC_W-1:0] == $past(flag_q)));

  a_r8_irq_follows: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (irq == $past(|(flag_q & ena_q & IRQ_MASK))));

  a_r10_other_write: assert property (@(posedge clk) disable iff (rst)
    (wr_en && reg_sel != FS && reg_sel != ES) |=> $stable(ena_q));
endmodule

bind ifc_ctrl ifc_ctrl_chk #(
  .SRC_W(SRC_W), .SEL_W(SEL_W), .FLAG_SEL(FLAG_SEL),
  .ENA_SEL(ENA_SEL), .IRQ_MASK(IRQ_MASK)
) u_chk (
  .clk(clk), .rst(rst), .src_set(src_set), .reg_sel(reg_sel),
  .rd_en(rd_en), .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data),
  .irq(irq), .flag_q(flag_q), .ena_q(ena_q)
);

// File: tb/sim_ifc_ctrl.sv
module sim_ifc_ctrl;
  localparam int CLK_P = 10;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [6:0] src_set = '0;
  logic [3:0] reg_sel = '0;
  logic       rd_en = 1'b0;
  logic       wr_en = 1'b0;
  logic [7:0] wr_data = '0;
  logic [7:0] rd_data;
  logic       irq;

  int total = 0;
  int bad   = 0;
  logic [6:0] m_flag = '0;
  logic [6:0] m_ena  = '0;

  always #(CLK_P/2) clk = ~clk;

  ifc_ctrl u0 (
    .clk(clk), .rst(rst), .src_set(src_set), .reg_sel(reg_sel),
    .rd_en(rd_en), .wr_en(wr_en), .wr_data(wr_data),
    .rd_data(rd_data), .irq(irq)
  );

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%02h expected=%02h", tag, act, exp);
    end
  endtask

  task automatic do_write(input logic [3:0] sel, input logic [7:0] d);
    @(negedge clk); reg_sel = sel; wr_data = d; wr_en = 1'b1;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic do_read(input logic [3:0] sel, output logic [7:0] d);
    @(negedge clk); reg_sel = sel; rd_en = 1'b1;
    @(negedge clk); rd_en = 1'b0; d = rd_data;
  endtask

  task automatic pulse(input logic [6:0] v);
    @(negedge clk); src_set = v;
    @(negedge clk); src_set = '0;
    m_flag = m_flag | v;
  endtask

  function automatic logic [7:0] exp_flag_read();
    return {|(m_flag & m_ena), m_flag};
  endfunction

  task automatic check_irq(input string tag);
    @(negedge clk);
    check(tag, {7'd0, irq}, {7'd0, |(m_flag & m_ena & 7'b100_0100)});
  endtask

  task automatic t_reset();
    logic [7:0] d;
    check("R1 irq after reset", {7'd0, irq}, 8'h00);
    check("R1 rd_data after reset", rd_data, 8'h00);
    do_read(4'd13, d); check("R1 flags zero", d, 8'h00);
    do_read(4'd14, d); check("R1/R7 enables zero, bit7 set", d, 8'h80);
  endtask

  task automatic t_set_and_enable();
    logic [7:0] d;
    pulse(7'h04);
    do_read(4'd13, d); check("R2/R4 shift flag set, not pending", d, exp_flag_read());
    check_irq("R8 irq low while disabled");
    do_write(4'd14, 8'h84); m_ena = m_ena | 7'h04;
    do_read(4'd14, d); check("R5/R7 enable set", d, {1'b1, m_ena});
    do_read(4'd13, d); check("R4 pending bit", d, exp_flag_read());
    check_irq("R8 irq high shift flag");
  endtask

  task automatic t_timer2_no_irq();
    logic [7:0] d;
    pulse(7'h20);
    do_write(4'd14, 8'hA0); m_ena = m_ena | 7'h20;
    do_write(4'd13, 8'h04); m_flag = m_flag & ~7'h04;
    do_read(4'd13, d); check("R3/R4 timer2 pending only", d, exp_flag_read());
    check_irq("R8 timer2 does not drive irq");
  endtask

  task automatic t_partial_clear();
    logic [7:0] d;
    pulse(7'h44);
    do_write(4'd13, 8'h40); m_flag = m_flag & ~7'h40;
    do_read(4'd13, d); check("R3 only written bit cleared", d, exp_flag_read());
    check_irq("R8 irq after partial clear");
  endtask

  task automatic t_disable();
    logic [7:0] d;
    do_write(4'd14, 8'h04); m_ena = m_ena & ~7'h04;
    do_read(4'd14, d); check("R6 enable cleared", d, {1'b1, m_ena});
    check_irq("R8 irq low after disable");
  endtask

  task automatic t_collide();
    logic [7:0] d;
    do_write(4'd14, 8'hC0); m_ena = m_ena | 7'h40;
    @(negedge clk); src_set = 7'h40; reg_sel = 4'd13; wr_data = 8'h40; wr_en = 1'b1;
    @(negedge clk); src_set = '0; wr_en = 1'b0;
    m_flag = m_flag | 7'h40;
    do_read(4'd13, d); check("R9 set wins over clear", d, exp_flag_read());
    check_irq("R8 irq high timer1 flag");
  endtask

  task automatic t_other_selects();
    logic [7:0] d;
    do_write(4'd3, 8'hFF);
    do_write(4'd15, 8'h7F);
    do_write(4'd0, 8'h00);
    do_read(4'd13, d); check("R10 flags untouched", d, exp_flag_read());
    do_read(4'd14, d); check("R10 enables untouched", d, {1'b1, m_ena});
    do_read(4'd5, d);  check("R10 other read is zero", d, 8'h00);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_set_and_enable();
    t_timer2_no_irq();
    t_partial_clear();
    t_disable();
    t_collide();
    t_other_selects();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(CLK_P * 20000);
    total++; bad++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule